// File: doc/BRIEF.md
# Boot-mode selection sequencer

This controller runs once after every device reset and decides whether the processor enters a loader or starts user code. It first points execution at the boot ROM vector 8000h. It then waits a fixed settle interval and pulses a reset to the serial slave logic. Next it raises the write-lock flag and then the read-out-disable flag. Last, it checks the loader requests in priority order.

A request from the JTAG side keeps the device in JTAG loader mode until the next reset. An I2C request puts the serial slave into loader mode at address 36h, with the source select set to I2C. The block then waits for the host's exit command and releases execution to the user vector 0000h. With no request, execution goes to 0000h straight away.

The I2C request is set by the host through a command written to address 34h. It must survive ordinary resets, so only a separate power-on reset clears it.

Top module: `boot_mode_seq`

## Requirements
- R1: In the first cycle after reset is released, jump_vld is high for exactly one cycle with jump_tgt = 16'h8000. jump_vld is only ever a one-cycle pulse.
- R2: For the WAIT_CYC cycles (default 320) that follow the boot-vector cycle, slv_rst, pwl and rod all stay low.
- R3: In the cycle after the wait, slv_rst is high for exactly one cycle. pwl reads 1 from two cycles after that pulse. rod reads 1 one cycle later than pwl. Both then stay high until reset.
- R4: In the check cycle (one cycle after rod rises), a high jtag_req takes priority over any I2C request. The block then stays in JTAG loader mode until reset: pss = 2'b00, slv_en = 0, and no further jump_vld.
- R5: A write (i2c_wr = 1) of data F0h to address 7'h34, strobed by i2c_stb, sets the I2C loader request. This works in any state. The request is kept through rst and cleared only by por or by the exit command.
- R6: If jtag_req is low and the I2C request is set in the check cycle, then from the next cycle pss = 2'b01 (encoding: 2'b00 JTAG, 2'b01 I2C), slv_en = 1 and slv_addr = 7'h36. While not in I2C loader mode, slv_addr = 7'h34 and slv_en = 0.
- R7: In I2C loader mode, a write of F0h to address 7'h36 makes jump_vld high in that same cycle with jump_tgt = 16'h0000. From the next cycle slv_en is 0, and the I2C request is cleared.
- R8: If neither request is set in the check cycle, jump_vld is high in that cycle with jump_tgt = 16'h0000. The block then stays in user mode with slv_en = 0.
- R9: Read strobes (i2c_wr = 0), other data values and other addresses have no effect on the request, the mode or any output.
- R10: While rst is high and in the first cycle after it, pss = 2'b00, pwl = 0 and rod = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high device reset, synchronous |
| por | input | 1 | Active-high power-on reset; clears the I2C loader request only |
| jtag_req | input | 1 | JTAG loader request level, set by an external programmer |
| i2c_stb | input | 1 | One-cycle strobe of a decoded I2C byte transaction |
| i2c_addr | input | 7 | 7-bit slave address of the transaction |
| i2c_wr | input | 1 | 1 = write, 0 = read |
| i2c_data | input | 8 | Data byte of the transaction |
| jump_vld | output | 1 | One-cycle pulse: execution moves to jump_tgt |
| jump_tgt | output | 16 | Jump target address |
| pss | output | 2 | Programming source select: 00 JTAG, 01 I2C |
| slv_en | output | 1 | I2C slave enabled for the loader |
| slv_addr | output | 7 | Slave address the block currently answers |
| slv_rst | output | 1 | One-cycle reset pulse to the serial slave logic |
| pwl | output | 1 | Program write-lock flag |
| rod | output | 1 | Read-out-disable flag |

## Verification
The bound checker watches several rules on every cycle:
- jump_vld is never longer than one cycle.
- The slave reset is a single pulse.
- rod never stands without pwl.
- Loader enable always comes with source 01 and address 36h.
- An exit jump drops the enable on the next cycle.

Only the bench's scenarios can show the other properties:
- The exact length of the settle interval.
- JTAG priority over a pending I2C request.
- The request staying set through a plain reset but not through a power-on reset.
- Reads and wrong bytes being ignored.

The bench shows these by following a behavioural model through whole reset sequences.

// File: rtl/boot_mode_seq.sv
module boot_mode_seq #(
  parameter int WAIT_CYC = 320,
  parameter logic [15:0] BOOT_VEC = 16'h8000,
  parameter logic [15:0] USER_VEC = 16'h0000,
  parameter logic [6:0] REQ_ADDR = 7'h34,
  parameter logic [6:0] LDR_ADDR = 7'h36,
  parameter logic [7:0] CMD_BYTE = 8'hF0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        por,
  input  logic        jtag_req,
  input  logic        i2c_stb,
  input  logic [6:0]  i2c_addr,
  input  logic        i2c_wr,
  input  logic [7:0]  i2c_data,
  output logic        jump_vld,
  output logic [15:0] jump_tgt,
  output logic [1:0]  pss,
  output logic        slv_en,
  output logic [6:0]  slv_addr,
  output logic        slv_rst,
  output logic        pwl,
  output logic        rod
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  typedef enum logic [3:0] {
    S_BOOT, S_WAIT, S_SRST, S_PWL, S_ROD, S_CHK, S_JLDR, S_ILDR, S_RUN
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic req;

  wire cmd_wr  = i2c_stb && i2c_wr && (i2c_data == CMD_BYTE);
  wire req_wr  = cmd_wr && (i2c_addr == REQ_ADDR);
  wire exit_wr = cmd_wr && (i2c_addr == LDR_ADDR) && (st == S_ILDR);
  wire go_user = (st == S_CHK) && !jtag_req && !req;

  assign jump_vld = (st == S_BOOT) || go_user || exit_wr;
  assign jump_tgt = (st == S_BOOT) ? BOOT_VEC : USER_VEC;
  assign slv_en   = (st == S_ILDR);
  assign slv_addr = slv_en ? LDR_ADDR : REQ_ADDR;
  assign slv_rst  = (st == S_SRST);

  always_ff @(posedge clk) begin
    if (por) req <= 1'b0;
    else if (exit_wr) req <= 1'b0;
    else if (req_wr) req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_BOOT;
      cnt <= '0;
      pss <= 2'b00;
      pwl <= 1'b0;
      rod <= 1'b0;
    end else begin
      unique case (st)
        S_BOOT: begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_SRST;
        end
        S_SRST: st <= S_PWL;
        S_PWL: begin
          pwl <= 1'b1;
          st  <= S_ROD;
        end
        S_ROD: begin
          rod <= 1'b1;
          st  <= S_CHK;
        end
        S_CHK: begin
          if (jtag_req) begin
            pss <= 2'b00;
            st  <= S_JLDR;
          end else if (req) begin
            pss <= 2'b01;
            st  <= S_ILDR;
          end else begin
            st  <= S_RUN;
          end
        end
        S_ILDR: if (exit_wr) st <= S_RUN;
        S_JLDR: st <= S_JLDR;
        S_RUN:  st <= S_RUN;
        default: st <= S_BOOT;
      endcase
    end
  end
endmodule

module boot_mode_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        jump_vld,
  input logic [1:0]  pss,
  input logic        slv_en,
  input logic [6:0]  slv_addr,
  input logic        slv_rst,
  input logic        pwl,
  input logic        rod
);
  // R1
  jump_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    jump_vld |=> !jump_vld);
  // R3
  slv_rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    slv_rst |=> !slv_rst);
  // R3
  rod_after_pwl_chk: assert property (@(posedge clk) disable iff (rst)
    rod |-> pwl);
  // R6
  ldr_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    slv_en |-> (pss == 2'b01 && slv_addr == 7'h36));
  // R7
  exit_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (slv_en && jump_vld) |=> !slv_en);
endmodule

bind boot_mode_seq boot_mode_seq_chk u_chk (
  .clk(clk), .rst(rst), .jump_vld(jump_vld), .pss(pss), .slv_en(slv_en),
  .slv_addr(slv_addr), .slv_rst(slv_rst), .pwl(pwl), .rod(rod)
);

// File: tb/sim_boot_mode_seq.sv
module sim_boot_mode_seq;
  localparam int W = 320;
  logic clk = 0, rst = 1, por = 1, jtag_req = 0;
  logic i2c_stb = 0, i2c_wr = 0;
  logic [6:0] i2c_addr = 0;
  logic [7:0] i2c_data = 0;
  logic jump_vld, slv_en, slv_rst, pwl, rod;
  logic [15:0] jump_tgt;
  logic [1:0] pss;
  logic [6:0] slv_addr;
  int tests = 0, fails = 0, cyc = 0;

  boot_mode_seq u0 (.*);

  always #2.5 clk = ~clk;

  // model: mode 0 sequencing, 1 JTAG loader, 2 I2C loader, 3 user
  int n = 0, mode = 0;
  bit mreq = 0;
  logic [1:0] mpss = 0;

  function automatic bit m_exit();
    return mode == 2 && i2c_stb && i2c_wr && i2c_data == 8'hF0 && i2c_addr == 7'h36;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      n = 0; mode = 0; mpss = 0;
    end else begin
      if (mode == 0 && n == W + 4) begin
        if (jtag_req) begin mode = 1; mpss = 2'b00; end
        else if (mreq) begin mode = 2; mpss = 2'b01; end
        else mode = 3;
      end else if (m_exit()) begin
        mode = 3; mreq = 0;
      end
      if (n < 1000000) n = n + 1;
    end
    if (por) mreq = 0;
    else if (i2c_stb && i2c_wr && i2c_data == 8'hF0 && i2c_addr == 7'h34) mreq = 1;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit ej, bt;
      bt = (mode == 0 && n == 0);
      ej = bt || (mode == 0 && n == W + 4 && !jtag_req && !mreq) || m_exit();
      chk(bt ? "R1 jump_vld" : (mode == 2 ? "R7 jump_vld" : "R8 jump_vld"), int'(jump_vld), int'(ej));
      if (ej) chk("R1 R7 R8 jump_tgt", int'(jump_tgt), bt ? 32'h8000 : 32'h0000);
      chk("R2 R3 slv_rst", int'(slv_rst), int'(mode == 0 && n == W + 1));
      chk("R2 R3 pwl", int'(pwl), int'(mode != 0 || n >= W + 3));
      chk("R2 R3 rod", int'(rod), int'(mode != 0 || n >= W + 4));
      chk("R4 R6 pss", int'(pss), int'(mpss));
      chk("R4 R6 slv_en", int'(slv_en), int'(mode == 2));
      chk("R6 slv_addr", int'(slv_addr), mode == 2 ? 32'h36 : 32'h34);
      if (n == 0) begin
        chk("R10 pss", int'(pss), 0);
        chk("R10 pwl", int'(pwl), 0);
        chk("R10 rod", int'(rod), 0);
      end
    end
  end

  task automatic tick(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit p);
    @(posedge clk); #1 rst = 1; por = p;
    tick(3);
    rst = 0; por = 0;
  endtask

  task automatic xfer(logic [6:0] a, logic w, logic [7:0] d);
    @(posedge clk); #1 i2c_stb = 1; i2c_addr = a; i2c_wr = w; i2c_data = d;
    @(posedge clk); #1 i2c_stb = 0;
  endtask

  initial begin
    tick(4);
    rst = 0; por = 0;
    tick(W + 20);                 // R8: no request, straight to user code
    chk("R8 final slv_en", int'(slv_en), 0);
    xfer(7'h34, 0, 8'hF0);        // R9: read ignored
    xfer(7'h34, 1, 8'h0F);        // R9: wrong data ignored
    xfer(7'h35, 1, 8'hF0);        // R9: wrong address ignored
    tick(5);
    do_reset(0);
    tick(W + 20);
    chk("R9 no loader after ignored writes", int'(slv_en), 0);
    xfer(7'h34, 1, 8'hF0);        // R5: set request
    do_reset(0);                  // R5: request survives rst
    tick(W + 10);
    chk("R6 loader entered", int'(slv_en), 1);
    xfer(7'h36, 1, 8'h0F);        // R9
    xfer(7'h36, 0, 8'hF0);        // R9
    xfer(7'h34, 1, 8'hF0);        // R9 in loader: no change
    tick(5);
    chk("R9 loader still active", int'(slv_en), 1);
    xfer(7'h36, 1, 8'hF0);        // R7: exit
    tick(5);
    chk("R7 loader left", int'(slv_en), 0);
    do_reset(0);                  // R7: request cleared, user code
    tick(W + 20);
    chk("R7 request cleared", int'(slv_en), 0);
    xfer(7'h34, 1, 8'hF0);
    jtag_req = 1;
    do_reset(0);                  // R4: JTAG wins
    tick(W + 60);
    chk("R4 jtag mode pss", int'(pss), 0);
    xfer(7'h36, 1, 8'hF0);
    tick(10);
    chk("R4 jtag mode held", int'(slv_en), 0);
    jtag_req = 0;
    do_reset(0);                  // R5: pending request still honoured
    tick(W + 10);
    chk("R5 request kept", int'(slv_en), 1);
    do_reset(1);                  // R5: por clears request
    tick(100);
    do_reset(0);                  // R2: reset during the wait restarts it
    tick(W + 20);
    chk("R5 por cleared request", int'(slv_en), 0);
    tick(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule